// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block gathers 39 maskable interrupt request lines from on-chip peripherals. These are general port inputs, key inputs, DMA end-of-transfer events, timer compare and underflow events, serial channel events, an A/D end-of-conversion and a clock timer. Each line sets a pending flag. Port lines can be configured for either edge or either level. Key lines can be configured for rising or falling edge. All other lines latch on a rising edge of their request.

A line competes for service only when its pending flag and its enable bit are both set. Among the competing lines, the one with the smallest source index wins. The block registers the winner's source index, its vector number and its vector address. The vector address is a programmable base plus four times the vector number. The vector numbers are sparse, and reserved numbers are never produced.

Thirty-one of the sources also have a numbered DMA trigger channel. When the route bit of such a source is set, each trigger event becomes a one-cycle channel pulse and no pending flag is set. Software configures the block through a write-only register port, addressed by `cfg_sel`, with data on `cfg_wdata`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An edge-class pending flag stays set after its input returns to its idle level. The flag clears only when software writes 1 to its bit with `cfg_sel`=2. A bit written as 0 leaves its flag unchanged.
- R2: When several sources are pending and enabled, the source with the smallest index is reported on `irq_src`. Index order is:
  - ports 0–3 (0–3)
  - keys 0–1 (4–5)
  - DMA 0–3 (6–9)
  - intelligent DMA (10)
  - timers 0–5, compare B then compare A (11–22)
  - 8-bit timer underflows 0–3 (23–26)
  - serial 0 error/rx/tx (27–29)
  - serial 1 error/rx/tx (30–32)
  - A/D (33)
  - clock timer (34)
  - ports 4–7 (35–38)
- R3: Source index i produces the following vector numbers:
  - 16+i for i=0..10
  - 30,31,34,35,38,39,42,43,46,47,50,51 for i=11..22
  - 52..58 for i=23..29
  - 60..62 for i=30..32
  - 64,65 for i=33,34
  - 68..71 for i=35..38

  The reserved numbers are never produced: 27–29, 32, 33, 36, 37, 40, 41, 44, 45, 48, 49, 59, 63, 66 and 67.
- R4: `irq_addr` equals the base plus 4 × `irq_vec`. The base is written with `cfg_sel`=0 from `cfg_wdata[31:0]`.
- R5: Port k has a 2-bit trigger field at `cfg_sel`=4 bits [2k+1:2k], with these codes:
  - 0: rising edge
  - 1: falling edge
  - 2: high level
  - 3: low level

  Port k is source k for k<4 and source 31+k otherwise.
- R6: Key j (source 4+j) has a trigger bit at `cfg_sel`=4 bit 16+j: 0 selects the rising edge and 1 selects the falling edge.
- R7: The enable mask is written with `cfg_sel`=1, one bit per source index. `irq_req` is high exactly one cycle after a source is both pending and enabled. A pending flag survives while its source is disabled.
- R8: A level-class flag follows its input's active level. A write-1 clear has no lasting effect while that level persists.
- R9: DMA channel numbers are assigned as follows, and channel c drives `dma_req[c-1]`:
  - sources 0–3 → channels 1–4
  - sources 6,7 → 5,6
  - sources 11–26 → 7–22
  - sources 28,29 → 23,24
  - sources 31,32 → 25,26
  - source 33 → 27
  - sources 35–38 → 28–31

  With its route bit set (`cfg_sel`=3), such a source pulses its channel for exactly one cycle after each trigger event and sets no pending flag.
- R10: Sources without a channel (4, 5, 8, 9, 10, 27, 30, 34) ignore their route bit and latch normally.
- R11: After synchronous reset the block is in this state:
  - all flags, enables, routes and trigger fields are zero
  - `irq_req`, `irq_src`, `irq_vec`, `irq_addr` and `dma_req` are zero

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 39 | Raw interrupt request lines, indexed by priority |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 base, 1 enable, 2 clear, 3 route, 4 trigger modes |
| cfg_wdata | input | 39 | Register write data |
| irq_req | output | 1 | A pending, enabled source exists |
| irq_src | output | 6 | Winning source index |
| irq_vec | output | 7 | Winning vector number |
| irq_addr | output | 32 | Vector address |
| dma_req | output | 31 | One-cycle DMA channel trigger pulses, bit c-1 for channel c |

## Verification
The one-cycle DMA pulse property assumes that a routed source's trigger mode does not change between two consecutive input transitions. Under that assumption, a trigger event can never repeat on back-to-back cycles. The stimulus meets this by writing trigger fields only while the affected inputs are idle. The address property compares against the base held in the previous cycle, so it does not depend on when software rewrites the base. Every input transition is driven between clock edges and held for at least one full cycle, so no edge is lost or seen twice.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_SRC   = 39;
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int VEC_W     = 7;
    localparam int ADDR_W    = 32;
    localparam int NUM_DMA   = 31;
    localparam int NUM_PORT  = 8;
    localparam int NUM_KEY   = 2;
    localparam int KEY_FIRST = 4;
    localparam int KEY_LSB   = 2 * NUM_PORT;
    localparam int TRIG_W    = 2 * NUM_PORT + NUM_KEY;
    localparam int CFG_W     = NUM_SRC;

    typedef enum logic [2:0] {
        REG_BASE   = 3'd0,
        REG_ENABLE = 3'd1,
        REG_CLEAR  = 3'd2,
        REG_ROUTE  = 3'd3,
        REG_TRIG   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        KIND_PORT  = 2'd0,
        KIND_KEY   = 2'd1,
        KIND_PULSE = 2'd2
    } src_kind_e;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } winner_t;

    typedef struct packed {
        logic              req;
        logic [SRC_W-1:0]  src;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] addr;
    } vec_out_t;

    // Sparse vector number for a source index; reserved gaps are skipped.
    function automatic logic [VEC_W-1:0] vec_of(int i);
        int v;
        if (i <= 10)      v = 16 + i;
        else if (i <= 22) v = 30 + 4 * ((i - 11) / 2) + ((i - 11) % 2);
        else if (i <= 29) v = 52 + (i - 23);
        else if (i <= 32) v = 60 + (i - 30);
        else if (i <= 34) v = 64 + (i - 33);
        else              v = 68 + (i - 35);
        return VEC_W'(v);
    endfunction

    // DMA trigger channel of a source, 0 when it has none.
    function automatic int dma_of(int i);
        if (i <= 3)                 return i + 1;
        if (i == 6 || i == 7)       return i - 1;
        if (i >= 11 && i <= 26)     return i - 4;
        if (i == 28 || i == 29)     return i - 5;
        if (i == 31 || i == 32)     return i - 6;
        if (i == 33)                return 27;
        if (i >= 35)                return i - 7;
        return 0;
    endfunction

    function automatic src_kind_e kind_of(int i);
        if (i <= 3 || i >= 35)                  return KIND_PORT;
        if (i >= KEY_FIRST && i < KEY_FIRST + NUM_KEY) return KIND_KEY;
        return KIND_PULSE;
    endfunction

    function automatic int port_num_of(int i);
        return (i <= 3) ? i : i - 31;
    endfunction

endpackage

// File: rtl/irq_src_trigger.sv
module irq_src_trigger
    import irq_vec_pkg::*;
#(
    parameter src_kind_e KIND    = KIND_PULSE,
    parameter bit        HAS_DMA = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_in,
    input  logic [1:0] mode,
    input  logic       route,
    input  logic       clr,
    output logic       pend,
    output logic       dma_pulse
);

    logic prev_q;
    logic rise_w, fall_w;
    logic event_w, level_w, active_w, to_dma;

    assign rise_w = src_in & ~prev_q;
    assign fall_w = ~src_in & prev_q;
    assign to_dma = HAS_DMA ? route : 1'b0;

    always_comb begin
        event_w  = rise_w;
        level_w  = 1'b0;
        active_w = src_in;
        case (KIND)
            KIND_PORT: begin
                case (mode)
                    TRIG_FALL: event_w = fall_w;
                    TRIG_HIGH: level_w = 1'b1;
                    TRIG_LOW: begin
                        level_w  = 1'b1;
                        active_w = ~src_in;
                        event_w  = fall_w;
                    end
                    default:   event_w = rise_w;
                endcase
            end
            KIND_KEY:  event_w = mode[0] ? fall_w : rise_w;
            default:   event_w = rise_w;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b0;
            pend      <= 1'b0;
            dma_pulse <= 1'b0;
        end else begin
            prev_q    <= src_in;
            dma_pulse <= event_w & to_dma;
            if (level_w)
                pend <= active_w & ~to_dma;
            else if (event_w & ~to_dma)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
(
    input  logic [NUM_SRC-1:0] cand,
    output winner_t            win,
    output logic [VEC_W-1:0]   win_vec
);

    always_comb begin
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win.valid = 1'b1;
                win.src   = SRC_W'(i);
            end
        end
    end

    always_comb begin
        win_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win.valid && win.src == SRC_W'(i))
                win_vec = vec_of(i);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic               irq_req,
    output logic [SRC_W-1:0]   irq_src,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [ADDR_W-1:0]  irq_addr,
    output logic [NUM_DMA-1:0] dma_req
);

    logic [ADDR_W-1:0]  base_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] route_q;
    logic [TRIG_W-1:0]  trig_q;
    logic [NUM_SRC-1:0] clr_w;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] cand;
    wire  [NUM_DMA-1:0] dma_w;
    winner_t            win;
    logic [VEC_W-1:0]   win_vec;
    vec_out_t           out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            en_q    <= '0;
            route_q <= '0;
            trig_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                REG_BASE:   base_q  <= cfg_wdata[ADDR_W-1:0];
                REG_ENABLE: en_q    <= cfg_wdata;
                REG_ROUTE:  route_q <= cfg_wdata;
                REG_TRIG:   trig_q  <= cfg_wdata[TRIG_W-1:0];
                default:    ;
            endcase
        end
    end

    assign clr_w = (cfg_we && cfg_sel == REG_CLEAR) ? cfg_wdata : '0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam src_kind_e K  = kind_of(i);
        localparam int        CH = dma_of(i);
        logic [1:0] mode_i;
        logic       pulse_i;

        if (K == KIND_PORT) begin : g_port
            assign mode_i = trig_q[2*port_num_of(i) +: 2];
        end else if (K == KIND_KEY) begin : g_key
            assign mode_i = {1'b0, trig_q[KEY_LSB + i - KEY_FIRST]};
        end else begin : g_pulse
            assign mode_i = 2'b00;
        end

        irq_src_trigger #(
            .KIND    (K),
            .HAS_DMA (CH != 0)
        ) u_trig (
            .clk       (clk),
            .rst       (rst),
            .src_in    (src_in[i]),
            .mode      (mode_i),
            .route     (route_q[i]),
            .clr       (clr_w[i]),
            .pend      (pend[i]),
            .dma_pulse (pulse_i)
        );

        if (CH != 0) begin : g_dma
            assign dma_w[CH-1] = pulse_i;
        end else begin : g_nodma
            logic unused_pulse;
            assign unused_pulse = pulse_i;
        end
    end

    assign cand = pend & en_q;

    irq_prio_pick u_pick (
        .cand    (cand),
        .win     (win),
        .win_vec (win_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.req  <= win.valid;
            out_q.src  <= win.src;
            out_q.vec  <= win_vec;
            out_q.addr <= win.valid ? base_q + {{(ADDR_W-VEC_W-2){1'b0}}, win_vec, 2'b00} : '0;
        end
    end

    assign irq_req  = out_q.req;
    assign irq_src  = out_q.src;
    assign irq_vec  = out_q.vec;
    assign irq_addr = out_q.addr;
    assign dma_req  = dma_w;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irq_vec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] cand,
    input logic [ADDR_W-1:0]  base_q,
    input logic               irq_req,
    input logic [SRC_W-1:0]   irq_src,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [ADDR_W-1:0]  irq_addr,
    input logic [NUM_DMA-1:0] dma_req
);

    function automatic bit legal_vec(logic [VEC_W-1:0] v);
        if (v < 16 || v > 71)                 return 1'b0;
        if (v >= 27 && v <= 29)               return 1'b0;
        if (v == 59 || v == 63)               return 1'b0;
        if (v == 66 || v == 67)               return 1'b0;
        if (v >= 32 && v <= 49 && (v % 4 < 2)) return 1'b0;
        return 1'b1;
    endfunction

    AST_REQ_RISES: assert property (@(posedge clk) disable iff (rst)
        (|cand) |=> irq_req); // R7

    AST_REQ_FALLS: assert property (@(posedge clk) disable iff (rst)
        !(|cand) |=> !irq_req); // R7

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> legal_vec(irq_vec)); // R3

    AST_ADDR_SUM: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_addr == $past(base_q) + {{(ADDR_W-VEC_W-2){1'b0}}, irq_vec, 2'b00}); // R4

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (($past(cand) >> irq_src) & NUM_SRC'(1)) != '0); // R2

    AST_NO_HIGHER: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ($past(cand) & ((NUM_SRC'(1) << irq_src) - NUM_SRC'(1))) == '0); // R2

    for (genvar c = 0; c < NUM_DMA; c++) begin : g_dma_chk
        AST_DMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            dma_req[c] |=> !dma_req[c]); // R9
    end

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cand     (cand),
    .base_q   (base_q),
    .irq_req  (irq_req),
    .irq_src  (irq_src),
    .irq_vec  (irq_vec),
    .irq_addr (irq_addr),
    .dma_req  (dma_req)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    import irq_vec_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] src_in = '0;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_sel = '0;
    logic [CFG_W-1:0]   cfg_wdata = '0;
    logic               irq_req;
    logic [SRC_W-1:0]   irq_src;
    logic [VEC_W-1:0]   irq_vec;
    logic [ADDR_W-1:0]  irq_addr;
    logic [NUM_DMA-1:0] dma_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    localparam logic [31:0] BASE = 32'h0C00_0000;
    localparam logic [CFG_W-1:0] ALL = '1;

    always #4 clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst(rst), .src_in(src_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec),
        .irq_addr(irq_addr), .dma_req(dma_req)
    );

    function automatic int want_vec(int i);
        case (i)
            11: return 30;  12: return 31;  13: return 34;  14: return 35;
            15: return 38;  16: return 39;  17: return 42;  18: return 43;
            19: return 46;  20: return 47;  21: return 50;  22: return 51;
            30: return 60;  31: return 61;  32: return 62;
            33: return 64;  34: return 65;
            default: begin
                if (i <= 10) return 16 + i;
                if (i <= 29) return 29 + i;
                return 33 + i;
            end
        endcase
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] sel, logic [CFG_W-1:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse(int i);
        src_in[i] = 1'b1;
        @(negedge clk);
        src_in[i] = 1'b0;
    endtask

    task automatic clear_all();
        wr(3'd2, ALL);
        step(1);
    endtask

    task automatic t_reset();
        chk("R11", "irq_req", irq_req, 0);
        chk("R11", "irq_vec", irq_vec, 0);
        chk("R11", "irq_addr", irq_addr, 0);
        chk("R11", "dma_req", dma_req, 0);
        pulse(3);
        step(1);
        chk("R11", "req with enables at reset value", irq_req, 0);
        clear_all();
    endtask

    task automatic t_latch();
        pulse(11);
        step(1);
        chk("R1", "req after pulse", irq_req, 1);
        chk("R3", "vec timer0 cmpB", irq_vec, 30);
        chk("R4", "addr timer0 cmpB", irq_addr, BASE + 32'h78);
        step(3);
        chk("R1", "req held after input idle", irq_req, 1);
        wr(3'd2, ALL & ~(CFG_W'(1) << 11));
        step(1);
        chk("R1", "zero clear bit ignored", irq_req, 1);
        wr(3'd2, CFG_W'(1) << 11);
        step(1);
        chk("R1", "req after write-1 clear", irq_req, 0);
    endtask

    task automatic t_priority();
        src_in[12] = 1'b1; src_in[20] = 1'b1;
        @(negedge clk);
        src_in[12] = 1'b0; src_in[20] = 1'b0;
        step(1);
        chk("R2", "winner src", irq_src, 12);
        chk("R2", "winner vec", irq_vec, 31);
        wr(3'd2, CFG_W'(1) << 12);
        step(1);
        chk("R2", "next src", irq_src, 20);
        chk("R2", "next vec", irq_vec, 47);
        clear_all();
    endtask

    task automatic t_sweep();
        for (int i = 0; i < NUM_SRC; i++) begin
            pulse(i);
            step(1);
            chk("R3", "sweep src", irq_src, i);
            chk("R3", "sweep vec", irq_vec, want_vec(i));
            chk("R4", "sweep addr", irq_addr, BASE + 32'(4 * want_vec(i)));
            clear_all();
        end
    endtask

    task automatic t_enable();
        wr(3'd1, ALL & ~(CFG_W'(1) << 5));
        pulse(5);
        step(1);
        chk("R7", "disabled source silent", irq_req, 0);
        wr(3'd1, ALL);
        step(1);
        chk("R7", "flag kept while disabled", irq_req, 1);
        chk("R7", "vec key1", irq_vec, 21);
        clear_all();
        chk("R7", "no candidate", irq_req, 0);
    endtask

    task automatic t_port_modes();
        wr(3'd4, CFG_W'(2'b01) << 4);
        src_in[2] = 1'b1;
        step(2);
        chk("R5", "falling mode ignores rise", irq_req, 0);
        src_in[2] = 1'b0;
        step(2);
        chk("R5", "falling mode fires", irq_vec, 18);
        clear_all();
        wr(3'd4, CFG_W'(2'b10) << 10);
        src_in[36] = 1'b1;
        step(2);
        chk("R5", "high level port5 req", irq_req, 1);
        chk("R5", "high level port5 vec", irq_vec, 69);
        wr(3'd2, CFG_W'(1) << 36);
        step(1);
        chk("R8", "level flag survives clear", irq_req, 1);
        src_in[36] = 1'b0;
        step(2);
        chk("R8", "level flag follows input", irq_req, 0);
        src_in[0] = 1'b1;
        wr(3'd0, CFG_W'(BASE));
        step(1);
        clear_all();
        wr(3'd4, CFG_W'(2'b11));
        step(1);
        chk("R5", "low level with input high", irq_req, 0);
        src_in[0] = 1'b0;
        step(2);
        chk("R5", "low level port0 vec", irq_vec, 16);
        src_in[0] = 1'b1;
        step(2);
        chk("R8", "low level released", irq_req, 0);
        wr(3'd4, '0);
        src_in[0] = 1'b0;
        step(1);
        clear_all();
    endtask

    task automatic t_key_mode();
        wr(3'd4, CFG_W'(1) << 17);
        src_in[5] = 1'b1;
        step(2);
        chk("R6", "key falling ignores rise", irq_req, 0);
        src_in[5] = 1'b0;
        step(2);
        chk("R6", "key falling fires", irq_vec, 21);
        wr(3'd4, '0);
        clear_all();
    endtask

    task automatic t_dma();
        wr(3'd3, (CFG_W'(1) << 7) | (CFG_W'(1) << 35));
        src_in[7] = 1'b1;
        @(negedge clk);
        chk("R9", "dma ch6 pulse", dma_req, 31'h20);
        src_in[7] = 1'b0;
        @(negedge clk);
        chk("R9", "dma pulse one cycle", dma_req, 0);
        chk("R9", "routed source no irq", irq_req, 0);
        src_in[35] = 1'b1;
        @(negedge clk);
        chk("R9", "dma ch28 pulse", dma_req, 31'h0800_0000);
        src_in[35] = 1'b0;
        step(2);
        chk("R9", "routed port no irq", irq_req, 0);
        wr(3'd3, ALL);
        src_in[4] = 1'b1;
        @(negedge clk);
        chk("R10", "no-channel source no dma", dma_req, 0);
        src_in[4] = 1'b0;
        step(1);
        chk("R10", "no-channel source latches", irq_req, 1);
        chk("R10", "no-channel vec", irq_vec, 20);
        wr(3'd3, '0);
        clear_all();
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        wr(3'd0, CFG_W'(BASE));
        wr(3'd1, ALL);
        step(1);
        t_latch();
        t_priority();
        t_sweep();
        t_enable();
        t_port_modes();
        t_key_mode();
        t_dma();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule